// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating converter. It drives an external analog front end through a two-bit phase code and reads back one comparator bit. It waits in the nulling phase until software or a host block pulses start. It then runs a timed nulling phase and a timed input integration. Next it switches the reference in and counts clock ticks until the comparator falls. It finishes by driving the integrator-output-zero phase until the comparator rises again.

The comparator passes through a two-flop synchronizer before any decision is made. A programmable correction is subtracted from the raw tick count. This correction absorbs the comparator delay and the synchronizer latency. On completion the block presents a signed count, the sampled polarity, an overrange flag and a one-cycle done strobe. A programmable ceiling on the deintegrate and output-zero phases makes a stuck comparator end in an abort rather than a hang.

Top module: `dsadc_ctrl`

## Requirements
- R1: After reset, `ab_o` is 01, and `done_o`, `ovr_o`, `pol_o` and `count_o` are all 0.
- R2: The phase code is 01 for auto-zero, 10 for integrate, 11 for deintegrate and 00 for output-zero. The code only ever steps 01→10→11→00→01, or 11→01 on an abort.
- R3: `ab_o` stays 01 until start is sampled high. The auto-zero phase then lasts `az_len_i` clocks (a value of 0 acts as 1) before the code turns to 10.
- R4: The integrate phase lasts exactly `int_len_i` clocks. Comparator activity during it, including edges, changes neither its length nor the sequence.
- R5: Polarity is taken from the synchronized comparator in the last integrate clock. A value of 1 gives `pol_o` = 1 (positive), and 0 gives `pol_o` = 0.
- R6: Count the clocks from the first clock with the code at 11 up to the clock in which the twice-registered comparator is seen falling. If the comparator falls just after the Nth clock edge following entry, that count is N+2. `count_o` is this count minus `corr_i`, floored at 0, and is negated when the polarity is 0. The 11 code is held for N+3 clocks.
- R7: The code stays 00 while the synchronized comparator is low. It leaves for 01 on the clock right after the synchronized comparator is seen high. A comparator rise therefore reaches `ab_o` on the third clock edge.
- R8: If no falling edge is seen within `max_len_i` deintegrate clocks, the block returns to 01 and sets `ovr_o` = 1 with `count_o` = 0.
- R9: If the output-zero phase lasts `max_len_i` clocks, the block returns to 01 and sets `ovr_o` = 1. `count_o` keeps the corrected deintegrate count.
- R10: `done_o` is high for exactly one clock: the first 01 clock after a conversion or an abort. The result outputs change only with it and hold until the next `done_o`.
- R11: A start pulse that arrives while a conversion is in progress has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (acted on only when idle) |
| cmp_i | input | 1 | Asynchronous comparator bit from the front end |
| az_len_i | input | CNT_W | Auto-zero length in clocks |
| int_len_i | input | CNT_W | Integrate length in clocks |
| max_len_i | input | CNT_W | Ceiling for deintegrate and output-zero phases |
| corr_i | input | CNT_W | Ticks subtracted from the raw count |
| ab_o | output | 2 | Phase code to the front end |
| count_o | output | CNT_W+1 | Signed corrected deintegration count |
| pol_o | output | 1 | Sampled input polarity, 1 = positive |
| ovr_o | output | 1 | Overrange / abort flag |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A wrong sequencer state appears at once on `ab_o` as a length error or an illegal step in the phase code. The bench therefore counts the clocks spent in every code and checks each one. A timer or capture fault shows up as a count off by a known number of ticks, or as a wrong sign, in the single cycle that `done_o` is high. The bench places comparator edges on chosen clocks, so each expected count is exact. A missed exit from output-zero shows within three clocks of the comparator rise. A stuck comparator shows as `max_len_i` clocks in one phase followed by `ovr_o`.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [1:0] {
        AB_IOZ   = 2'b00,
        AB_AZ    = 2'b01,
        AB_INT   = 2'b10,
        AB_DEINT = 2'b11
    } ab_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_AZ,
        S_INT,
        S_DEINT,
        S_IOZ
    } seq_st_e;

    typedef struct packed {
        logic pol_cap;      // last integrate clock
        logic fall_hit;     // comparator fall seen in deintegrate
        logic finish;       // clean exit from output-zero
        logic abort_deint;  // deintegrate ceiling reached
        logic abort_ioz;    // output-zero ceiling reached
    } seq_evt_t;

    function automatic ab_e ab_of(seq_st_e s);
        case (s)
            S_INT:   return AB_INT;
            S_DEINT: return AB_DEINT;
            S_IOZ:   return AB_IOZ;
            default: return AB_AZ;
        endcase
    endfunction

    function automatic logic ab_step_ok(logic [1:0] from, logic [1:0] to);
        case (from)
            2'b01:   return to == 2'b10;
            2'b10:   return to == 2'b11;
            2'b11:   return (to == 2'b00) || (to == 2'b01);
            default: return to == 2'b01;
        endcase
    endfunction

endpackage

// File: rtl/dsadc_sync.sv
module dsadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic lvl_o,
    output logic fall_o
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain;
    logic          lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            lvl_d <= 1'b0;
        end else begin
            for (int k = LAST; k > 0; k--) chain[k] <= chain[k-1];
            chain[0] <= async_i;
            lvl_d    <= chain[LAST];
        end
    end

    assign lvl_o  = chain[LAST];
    assign fall_o = lvl_d & ~chain[LAST];

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             cs_i,
    input  logic             fall_i,
    input  logic [CNT_W-1:0] az_len_i,
    input  logic [CNT_W-1:0] int_len_i,
    input  logic [CNT_W-1:0] max_len_i,
    output seq_st_e          st_o,
    output logic [CNT_W-1:0] tmr_o,
    output seq_evt_t         evt_o
);
    seq_st_e          st, st_nxt;
    logic [CNT_W-1:0] tmr;

    function automatic logic at_end(logic [CNT_W-1:0] t, logic [CNT_W-1:0] len);
        return ({1'b0, t} + 1'b1) >= {1'b0, len};
    endfunction

    always_comb begin
        st_nxt = st;
        evt_o  = '0;
        case (st)
            S_IDLE:  if (start_i) st_nxt = S_AZ;
            S_AZ:    if (at_end(tmr, az_len_i)) st_nxt = S_INT;
            S_INT: begin
                if (at_end(tmr, int_len_i)) begin
                    st_nxt        = S_DEINT;
                    evt_o.pol_cap = 1'b1;
                end
            end
            S_DEINT: begin
                if (fall_i) begin
                    st_nxt         = S_IOZ;
                    evt_o.fall_hit = 1'b1;
                end else if (at_end(tmr, max_len_i)) begin
                    st_nxt            = S_IDLE;
                    evt_o.abort_deint = 1'b1;
                end
            end
            S_IOZ: begin
                if (cs_i) begin
                    st_nxt       = S_IDLE;
                    evt_o.finish = 1'b1;
                end else if (at_end(tmr, max_len_i)) begin
                    st_nxt          = S_IDLE;
                    evt_o.abort_ioz = 1'b1;
                end
            end
            default: st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= S_IDLE;
            tmr <= '0;
        end else begin
            st  <= st_nxt;
            tmr <= (st_nxt != st || st == S_IDLE) ? '0 : tmr + 1'b1;
        end
    end

    assign st_o  = st;
    assign tmr_o = tmr;

    // R2: phase code only takes legal steps
    p_ab_legal_r2: assert property (@(posedge clk) disable iff (rst)
        (ab_of(st_nxt) != ab_of(st)) |-> ab_step_ok(ab_of(st), ab_of(st_nxt)));

    // R4: integrate is never cut short, whatever the comparator does
    p_int_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (st == S_INT && !at_end(tmr, int_len_i)) |=> (st == S_INT));

    // R7: output-zero ends the clock after the synced comparator is high
    p_ioz_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (st == S_IOZ && cs_i) |=> (st == S_IDLE));

    // R8: the deintegrate timer never passes the ceiling
    p_deint_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (st == S_DEINT && max_len_i != '0) |-> (tmr < max_len_i));

    // R11: a conversion in flight never restarts auto-zero
    p_no_restart_r11: assert property (@(posedge clk) disable iff (rst)
        (st != S_IDLE && st != S_AZ) |=> (st != S_AZ));

endmodule

// File: rtl/dsadc_result.sv
module dsadc_result
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  seq_evt_t                evt_i,
    input  logic                    cs_i,
    input  logic [CNT_W-1:0]        tmr_i,
    input  logic [CNT_W-1:0]        corr_i,
    output logic signed [CNT_W:0]   count_o,
    output logic                    pol_o,
    output logic                    ovr_o,
    output logic                    done_o
);
    logic [CNT_W-1:0]      raw_q, mag_q;
    logic                  pol_cap_q;
    logic signed [CNT_W:0] smag;

    function automatic logic [CNT_W-1:0] trim(logic [CNT_W-1:0] raw, logic [CNT_W-1:0] c);
        return (raw > c) ? raw - c : '0;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q     <= '0;
            mag_q     <= '0;
            pol_cap_q <= 1'b0;
            pol_o     <= 1'b0;
            ovr_o     <= 1'b0;
            done_o    <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (evt_i.pol_cap)  pol_cap_q <= cs_i;
            if (evt_i.fall_hit) raw_q     <= tmr_i;
            if (evt_i.finish || evt_i.abort_ioz) begin
                mag_q  <= trim(raw_q, corr_i);
                pol_o  <= pol_cap_q;
                ovr_o  <= evt_i.abort_ioz;
                done_o <= 1'b1;
            end else if (evt_i.abort_deint) begin
                mag_q  <= '0;
                pol_o  <= pol_cap_q;
                ovr_o  <= 1'b1;
                done_o <= 1'b1;
            end
        end
    end

    assign smag    = $signed({1'b0, mag_q});
    assign count_o = pol_o ? smag : -smag;

    // R10: done is a single-cycle strobe
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: the result only moves together with done
    p_result_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !($stable(mag_q) && $stable(ovr_o) && $stable(pol_o)) |-> done_o);

endmodule

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
    import dsadc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start_i,
    input  logic                  cmp_i,
    input  logic [CNT_W-1:0]      az_len_i,
    input  logic [CNT_W-1:0]      int_len_i,
    input  logic [CNT_W-1:0]      max_len_i,
    input  logic [CNT_W-1:0]      corr_i,
    output logic [1:0]            ab_o,
    output logic signed [CNT_W:0] count_o,
    output logic                  pol_o,
    output logic                  ovr_o,
    output logic                  done_o
);
    logic             cs, cs_fall;
    seq_st_e          st;
    logic [CNT_W-1:0] tmr;
    seq_evt_t         evt;

    dsadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (cmp_i),
        .lvl_o   (cs),
        .fall_o  (cs_fall)
    );

    dsadc_seq #(.CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .cs_i      (cs),
        .fall_i    (cs_fall),
        .az_len_i  (az_len_i),
        .int_len_i (int_len_i),
        .max_len_i (max_len_i),
        .st_o      (st),
        .tmr_o     (tmr),
        .evt_o     (evt)
    );

    dsadc_result #(.CNT_W(CNT_W)) u_res (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .cs_i    (cs),
        .tmr_i   (tmr),
        .corr_i  (corr_i),
        .count_o (count_o),
        .pol_o   (pol_o),
        .ovr_o   (ovr_o),
        .done_o  (done_o)
    );

    assign ab_o = ab_of(st);

    // R1/R10: done only ever coincides with the auto-zero code
    p_done_in_az_r10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (ab_o == 2'b01));

endmodule

// File: tb/dsadc_ctrl_tb_top.sv
module dsadc_ctrl_tb_top;
    localparam int CNT_W = 16;

    logic                  clk = 1'b0;
    logic                  rst;
    logic                  start_i = 1'b0;
    logic                  cmp_i = 1'b1;
    logic [CNT_W-1:0]      az_len_i, int_len_i, max_len_i, corr_i;
    logic [1:0]            ab_o;
    logic signed [CNT_W:0] count_o;
    logic                  pol_o, ovr_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    dsadc_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk (clk), .rst (rst), .start_i (start_i), .cmp_i (cmp_i),
        .az_len_i (az_len_i), .int_len_i (int_len_i),
        .max_len_i (max_len_i), .corr_i (corr_i),
        .ab_o (ab_o), .count_o (count_o), .pol_o (pol_o),
        .ovr_o (ovr_o), .done_o (done_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // mode 0: normal, 1: deintegrate timeout, 2: output-zero timeout
    task automatic conv(input bit pos, input int n, input bit noise,
                        input bit start_mid, input int mode);
        int cnt;
        longint mag, expc;
        mag  = (n + 2 > int'(corr_i)) ? longint'(n + 2 - int'(corr_i)) : 0;
        expc = pos ? mag : -mag;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        cnt = 0;
        while (ab_o == 2'b01 && cnt < 1000) begin cnt++; @(negedge clk); end
        chk(cnt == ((az_len_i == 0) ? 1 : int'(az_len_i)), "R3 auto-zero length", cnt, az_len_i);
        cnt = 0;
        while (ab_o == 2'b10 && cnt < 1000) begin
            if (noise && cnt < int'(int_len_i) / 2) cmp_i = (cnt % 2 == 1);
            if (cnt == int'(int_len_i) / 2) cmp_i = pos;
            if (start_mid) start_i = (cnt == 3);
            cnt++;
            @(negedge clk);
        end
        start_i = 1'b0;
        chk(cnt == int'(int_len_i), "R4 integrate length", cnt, int_len_i);
        chk(ab_o == 2'b11, "R2 code after integrate", ab_o, 3);
        if (!pos) cmp_i = 1'b1;
        if (mode == 1) begin
            cnt = 0;
            while (ab_o == 2'b11 && cnt < 10000) begin cnt++; @(negedge clk); end
            chk(cnt == int'(max_len_i), "R8 deintegrate ceiling", cnt, max_len_i);
            chk(ab_o == 2'b01 && done_o, "R8 abort to auto-zero with done", ab_o, 1);
            chk(ovr_o == 1'b1, "R8 overrange flag", ovr_o, 1);
            chk(count_o == 0, "R8 count cleared", count_o, 0);
        end else begin
            repeat (n) @(negedge clk);
            cmp_i = 1'b0;
            cnt = n;
            while (ab_o == 2'b11 && cnt < 10000) begin cnt++; @(negedge clk); end
            chk(cnt == n + 3, "R6 deintegrate clocks", cnt, n + 3);
            chk(ab_o == 2'b00, "R2 code after deintegrate", ab_o, 0);
            if (mode == 2) begin
                cnt = 0;
                while (ab_o == 2'b00 && cnt < 10000) begin cnt++; @(negedge clk); end
                chk(cnt == int'(max_len_i), "R9 output-zero ceiling", cnt, max_len_i);
                chk(ab_o == 2'b01 && done_o, "R9 abort with done", ab_o, 1);
                chk(ovr_o == 1'b1, "R9 overrange flag", ovr_o, 1);
                chk(count_o == expc, "R9 count kept", count_o, expc);
            end else begin
                for (int i = 0; i < 4; i++) begin
                    chk(ab_o == 2'b00, "R7 output-zero held while low", ab_o, 0);
                    @(negedge clk);
                end
                cmp_i = 1'b1;
                @(negedge clk); chk(ab_o == 2'b00, "R7 exit latency", ab_o, 0);
                @(negedge clk); chk(ab_o == 2'b00, "R7 exit latency", ab_o, 0);
                @(negedge clk);
                chk(ab_o == 2'b01, "R7 exit to auto-zero", ab_o, 1);
                chk(done_o == 1'b1, "R10 done with first auto-zero clock", done_o, 1);
                chk(count_o == expc, "R6 corrected signed count", count_o, expc);
                chk(pol_o == pos, "R5 polarity", pol_o, pos);
                chk(ovr_o == 1'b0, "R6 no overrange", ovr_o, 0);
            end
        end
        expc = count_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R10 done single cycle", done_o, 0);
        for (int i = 0; i < 5; i++) begin
            chk(ab_o == 2'b01 && !done_o, "R11 idle holds, no restart", ab_o, 1);
            @(negedge clk);
        end
        chk(count_o == expc, "R10 result holds", count_o, expc);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(ab_o == 2'b01, "R1 reset code", ab_o, 1);
        chk(!done_o && !ovr_o && !pol_o, "R1 reset flags", {done_o, ovr_o, pol_o}, 0);
        chk(count_o == 0, "R1 reset count", count_o, 0);
        repeat (6) @(negedge clk);
        chk(ab_o == 2'b01, "R3 idle without start", ab_o, 1);
    endtask

    task automatic t_positive;   conv(1'b1, 10, 1'b0, 1'b0, 0); endtask
    task automatic t_neg_noise;  conv(1'b0, 25, 1'b1, 1'b0, 0); endtask  // R4 R5
    task automatic t_start_mid;  conv(1'b1, 5, 1'b0, 1'b1, 0);  endtask  // R11
    task automatic t_floor;      corr_i = 12; conv(1'b0, 4, 1'b0, 1'b0, 0); corr_i = 2; endtask // R6
    task automatic t_deint_to;   max_len_i = 40; conv(1'b1, 0, 1'b0, 1'b0, 1); endtask // R8
    task automatic t_ioz_to;     max_len_i = 30; conv(1'b1, 5, 1'b0, 1'b0, 2); max_len_i = 200; endtask // R9
    task automatic t_short;      az_len_i = 0; int_len_i = 6; conv(1'b1, 3, 1'b0, 1'b0, 0); endtask // R3

    initial begin
        az_len_i = 7; int_len_i = 20; max_len_i = 200; corr_i = 2;
        t_reset();
        t_positive();
        t_neg_noise();
        t_start_mid();
        t_floor();
        t_deint_to();
        t_ioz_to();
        t_short();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule